// File: doc/BRIEF.md
# Pipelined Dual-Port Sample Demultiplexer

This block accepts one 24-bit sample word on every rising edge of the sample clock. The word is made of three 8-bit channels. After a fixed pipeline delay it delivers each word to one of two 24-bit output ports. Two static select inputs choose one of three modes:

- **Single-port:** every word leaves on port A.
- **Dual-port interleaved:** successive words alternate between the ports, and each port carries its own words at its own time.
- **Dual-port parallel:** words also alternate, but port A gets one extra register stage. Each consecutive pair of words then appears on both ports in the same cycle.

A half-rate output clock decides which port a word goes to. Its level on the edge where the word is captured selects port A (low) or port B (high). A sync input holds that clock low, which puts the alternation in a known order. Each port has a valid strobe that marks the cycles in which its data register takes a new word.

Top module: `dual_port_demux`

## Requirements
- R1: The mode comes from `sel_single` and `sel_ilv`. `sel_single`=1 selects single-port mode, and `sel_ilv` then has no effect. `sel_single`=0 with `sel_ilv`=1 selects interleaved mode. `sel_single`=0 with `sel_ilv`=0 selects parallel mode.
- R2: In both dual-port modes, words captured on consecutive edges outside sync go to opposite ports.
- R3: A word captured on edge N is loaded into its port register on edge N+5. This applies to every word except port A words in parallel mode.
- R4: The port is chosen by the level of `hclk_out` just before the capturing edge: 0 selects port A and 1 selects port B.
- R5: In parallel mode, port A words are loaded on edge N+6. A pair whose A word was captured on edge N and whose B word was captured on edge N+1 is therefore presented on both ports after the same edge.
- R6: `hclk_out` is 0 after any edge at which `sync` is 1, and it inverts on every edge at which `sync` is 0. As a result, the first word captured after sync is released goes to port A.
- R7: In single-port mode every word goes to port A, and `b_data`/`b_valid` never change.
- R8: Each valid strobe is 1 for exactly the cycles that follow an edge on which its port register loaded a word. While the strobe is 0, the port data holds its previous value.
- R9: A synchronous active-high `rst` clears the pipeline, both port registers, both strobes and `hclk_out`.
- R10: All 24 bits (three 8-bit channels) pass through unchanged, in their bit positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; a word is captured on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_single | input | 1 | 1 selects single-port mode |
| sel_ilv | input | 1 | In dual-port mode: 1 interleaved, 0 parallel |
| sync | input | 1 | Holds the half-rate clock low while 1 |
| sample_in | input | 24 | Three 8-bit channels |
| hclk_out | output | 1 | Half-rate output clock (registered) |
| a_data | output | 24 | Port A data |
| a_valid | output | 1 | Port A loaded a word on the last edge |
| b_data | output | 24 | Port B data |
| b_valid | output | 1 | Port B loaded a word on the last edge |

## Verification
The hardest situation to reach is a re-sync in the middle of a stream. When `sync` is raised while earlier words are still in flight, several consecutive words are steered to port A. Words already in the pipeline keep their original port. In parallel mode this breaks the A/B pairing for a few cycles.

The bench covers this case in each mode. It pulses `sync` once at start-up and again part way through the sweep. It predicts every port load from its own model of the half-rate clock and the mode latencies. Single-port mode is swept with both levels of `sel_ilv`.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_ILV = 2'd1,
    MODE_SGL = 2'd2
  } dmx_mode_e;

  function automatic dmx_mode_e decode_mode(input logic single, input logic ilv);
    if (single) return MODE_SGL;
    else if (ilv) return MODE_ILV;
    else return MODE_PAR;
  endfunction

endpackage

// File: rtl/dmx_phase.sv
module dmx_phase (
  input  logic clk,
  input  logic rst,
  input  logic sync,
  output logic hclk_q
);

  always_ff @(posedge clk) begin
    if (rst || sync) hclk_q <= 1'b0;
    else             hclk_q <= ~hclk_q;
  end

  // R6: while sync is asserted the half-rate clock is forced low
  a_r6_sync_holds_low: assert property (@(posedge clk) disable iff (rst)
    sync |=> !hclk_q);

  // R6: when free running it inverts on every edge
  a_r6_free_toggle: assert property (@(posedge clk) disable iff (rst)
    !sync |=> (hclk_q != $past(hclk_q)));

endmodule

// File: rtl/dmx_delay.sv
module dmx_delay #(
  parameter int W     = 25,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_d,
  input  logic         in_v,
  output logic [W-1:0] out_d,
  output logic         out_v
);

  logic [W-1:0] st_d [DEPTH];
  logic         st_v [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) begin
            st_d[0] <= '0;
            st_v[0] <= 1'b0;
          end else begin
            st_d[0] <= in_d;
            st_v[0] <= in_v;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) begin
            st_d[g] <= '0;
            st_v[g] <= 1'b0;
          end else begin
            st_d[g] <= st_d[g-1];
            st_v[g] <= st_v[g-1];
          end
        end
      end
    end
  endgenerate

  assign out_d = st_d[DEPTH-1];
  assign out_v = st_v[DEPTH-1];

endmodule

// File: rtl/dmx_steer.sv
module dmx_steer
  import dmx_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  dmx_mode_e     mode,
  input  logic [DW-1:0] tail_d,
  input  logic          tail_b,
  input  logic          tail_v,
  output logic [DW-1:0] a_d,
  output logic          a_v,
  output logic [DW-1:0] b_d,
  output logic          b_v
);

  logic          a_take;
  logic          b_take;
  logic [DW-1:0] al_d;
  logic          al_v;
  logic          is_par;

  assign a_take = tail_v && !tail_b;
  assign b_take = tail_v &&  tail_b;
  assign is_par = (mode == MODE_PAR);

  // alignment stage: only consumed in parallel format
  always_ff @(posedge clk) begin
    if (rst) begin
      al_d <= '0;
      al_v <= 1'b0;
    end else begin
      al_d <= tail_d;
      al_v <= a_take;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d <= '0;
      a_v <= 1'b0;
    end else if (is_par) begin
      a_v <= al_v;
      if (al_v) a_d <= al_d;
    end else begin
      a_v <= a_take;
      if (a_take) a_d <= tail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_d <= '0;
      b_v <= 1'b0;
    end else begin
      b_v <= b_take;
      if (b_take) b_d <= tail_d;
    end
  end

  // R2: outside parallel format the two ports never load on the same edge
  a_r2_ports_exclusive: assert property (@(posedge clk) disable iff (rst)
    !is_par |-> !(a_v && b_v));

  // R8: port A data only moves together with its strobe
  a_r8_a_hold: assert property (@(posedge clk) disable iff (rst)
    !a_v |-> $stable(a_d));

  // R8: port B data only moves together with its strobe
  a_r8_b_hold: assert property (@(posedge clk) disable iff (rst)
    !b_v |-> $stable(b_d));

  // R7: single-port mode keeps port B quiet
  a_r7_single_b_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SGL) && $past(mode == MODE_SGL) && !tail_b |=> !b_v);

endmodule

// File: rtl/dual_port_demux.sv
module dual_port_demux
  import dmx_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int N_CH = 3,
  parameter int LAT  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_single,
  input  logic                 sel_ilv,
  input  logic                 sync,
  input  logic [CH_W*N_CH-1:0] sample_in,
  output logic                 hclk_out,
  output logic [CH_W*N_CH-1:0] a_data,
  output logic                 a_valid,
  output logic [CH_W*N_CH-1:0] b_data,
  output logic                 b_valid
);

  localparam int DW    = CH_W * N_CH;
  localparam int TW    = DW + 1;
  localparam int DEPTH = LAT;

  dmx_mode_e     mode;
  logic          route_b;
  logic [TW-1:0] tail_w;
  logic          tail_v;

  assign mode    = decode_mode(sel_single, sel_ilv);
  assign route_b = (mode != MODE_SGL) && hclk_out;

  dmx_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .sync   (sync),
    .hclk_q (hclk_out)
  );

  dmx_delay #(.W(TW), .DEPTH(DEPTH)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .in_d  ({route_b, sample_in}),
    .in_v  (1'b1),
    .out_d (tail_w),
    .out_v (tail_v)
  );

  dmx_steer #(.DW(DW)) u_steer (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .tail_d (tail_w[DW-1:0]),
    .tail_b (tail_w[DW]),
    .tail_v (tail_v),
    .a_d    (a_data),
    .a_v    (a_valid),
    .b_d    (b_data),
    .b_v    (b_valid)
  );

  // R9: strobes are low on the first cycle out of reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !a_valid && !b_valid && !hclk_out);

endmodule

// File: tb/dual_port_demux_bench.sv
`timescale 1ns/1ps
module dual_port_demux_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_single = 1'b0;
  logic        sel_ilv = 1'b0;
  logic        sync = 1'b1;
  logic [23:0] sample_in = '0;
  logic        hclk_out;
  logic [23:0] a_data, b_data;
  logic        a_valid, b_valid;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [23:0] exp_ad [0:1023];
  logic [23:0] exp_bd [0:1023];
  bit          exp_av [0:1023];
  bit          exp_bv [0:1023];

  always #2 clk = ~clk;

  dual_port_demux u_dual_port_demux (
    .clk(clk), .rst(rst), .sel_single(sel_single), .sel_ilv(sel_ilv),
    .sync(sync), .sample_in(sample_in), .hclk_out(hclk_out),
    .a_data(a_data), .a_valid(a_valid), .b_data(b_data), .b_valid(b_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R10: three distinct channel patterns per word
  function automatic logic [23:0] word_of(input int e, input int id);
    logic [7:0] c0, c1, c2;
    c0 = 8'(e * 3 + id);
    c1 = 8'(e ^ 8'h5A);
    c2 = 8'(255 - e - id * 16);
    return {c2, c1, c0};
  endfunction

  task automatic run_mode(input bit oms, input bit ip, input int id);
    bit hc;
    bit par, dual, rb;
    int lat;
    int pairs;
    logic [23:0] last_a, last_b;
    string ta, tb;
    par  = !oms && !ip;
    dual = !oms;
    ta = oms ? "R1/R7 portA" : (par ? "R5 portA" : "R3/R4 portA");
    tb = oms ? "R7 portB"    : "R2/R4 portB";
    for (int i = 0; i < 1024; i++) begin
      exp_av[i] = 1'b0; exp_bv[i] = 1'b0; exp_ad[i] = '0; exp_bd[i] = '0;
    end
    @(negedge clk);
    rst = 1'b1; sel_single = oms; sel_ilv = ip; sync = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!a_valid && !b_valid, "R9 strobes", {a_valid, b_valid}, 0);
    chk(a_data == 0 && b_data == 0, "R9 data", a_data | b_data, 0);
    chk(!hclk_out, "R9 hclk", hclk_out, 0);
    rst = 1'b0;
    hc = 1'b0; last_a = '0; last_b = '0; pairs = 0;
    for (int e = 0; e < 140; e++) begin
      sync = (e < 4) || (e >= 61 && e < 64);
      sample_in = word_of(e, id);
      rb  = dual && hc;                     // R4
      lat = (par && !rb) ? 6 : 5;           // R3, R5
      if (rb) begin exp_bv[e + lat] = 1'b1; exp_bd[e + lat] = sample_in; end
      else    begin exp_av[e + lat] = 1'b1; exp_ad[e + lat] = sample_in; end
      hc = sync ? 1'b0 : ~hc;               // R6
      @(posedge clk);
      @(negedge clk);
      if (exp_av[e]) last_a = exp_ad[e];
      if (exp_bv[e]) last_b = exp_bd[e];
      chk(a_valid == exp_av[e], {ta, " R8 strobe"}, a_valid, exp_av[e]);
      chk(a_data == last_a, {ta, " R10 data"}, a_data, last_a);
      chk(b_valid == exp_bv[e], {tb, " R8 strobe"}, b_valid, exp_bv[e]);
      chk(b_data == last_b, {tb, " R10 data"}, b_data, last_b);
      chk(hclk_out == hc, "R6 hclk", hclk_out, hc);
      if (a_valid && b_valid) pairs++;
    end
    if (par) chk(pairs > 40, "R5 paired outputs", pairs, 41);
    if (oms) chk(b_data == 0, "R7 portB untouched", b_data, 0);
  endtask

  initial begin
    run_mode(1'b0, 1'b0, 0);   // parallel
    run_mode(1'b0, 1'b1, 1);   // interleaved
    run_mode(1'b1, 1'b0, 2);   // single, select low
    run_mode(1'b1, 1'b1, 3);   // single, select high (R1 ignored input)
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule